// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block controls a configurable number of general-purpose pins through a small word-addressed register bus. Pins are grouped into banks of 32, and each bank owns one 32-bit word per register kind: output value, direction, sampled input level, interrupt mask, pending status, edge polarity and pad enable. Software sets a pin up as an output by clearing its direction bit and setting its enable bit. The pad then carries the stored output value. Any other pin leaves its pad undriven.

Pad inputs are synchronised through two flops and then compared against one more flop of history to detect edges. Each pin selects rising or falling edges. When the block is built without the edge-polarity register, every pin is level sensitive and active high. An unmasked event latches a pending status bit. Software clears a bit by writing 0 to it and leaves it alone by writing 1. The single interrupt output is asserted while any pending bit is set.

The bus address is `{field[2:0], bank}`. Reads are combinational from the address. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every implemented pin reads as an input (direction bit 1) and as masked (mask bit 1). No status bit is set, `irq` is low and `pad_oe` is all zero.
- R2: Field codes are 0 output value, 1 direction, 2 input level (read only), 3 mask, 4 status, 5 edge polarity and 6 pad enable. Pin n uses bit n mod 32 of bank n/32, and a bank index of BANKS or above reads 0.
- R3: A pin whose direction bit is 0 and whose enable bit is 1 has `pad_oe` high and `pad_out` equal to its output-value bit. A direction bit of 1 keeps `pad_oe` low.
- R4: With HAS_ENABLE=1, a pin whose enable bit is 0 has `pad_oe` low whatever its direction bit is.
- R5: The input-level field returns the pad level that was present two clock edges earlier.
- R6: With HAS_EDGE=1, a polarity bit of 1 detects rising edges and 0 detects falling edges. The status bit is set on the third clock edge after the pad changes, and the opposite edge sets nothing.
- R7: A pin whose mask bit is 1 never sets its status bit.
- R8: Writing the status field clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle sets its bit.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: Bits at or above NUM_PINS in the last bank read 0 in every field, ignore writes and never set status.
- R11: With HAS_EDGE=0, a high, unmasked pin sets its status bit on every cycle, so a clear written while the pad stays high has no lasting effect. The polarity field reads 0.
- R12: With HAS_ENABLE=0, every pin behaves as enabled and the enable field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3+BANK_W | Field code in the upper 3 bits, bank index below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Output value per pad |
| pad_oe | output | NUM_PINS | Output enable per pad |
| irq | output | 1 | Combined pending interrupt |

## Verification
The bench builds two copies of the block. The first has 40 pins with both the polarity and enable registers present. That gives it a full bank and a partial second bank, which brings bank addressing, edge selection in both banks and the unused upper bits of the second bank within reach. The second copy has 20 pins with neither optional register. It exercises level-sensitive status that re-sets under a clear, pads that drive with no enable register, and reads of a bank index past the end of the pins.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int NUM_PINS   = 40,
  parameter bit HAS_EDGE   = 1'b1,
  parameter bit HAS_ENABLE = 1'b1,
  localparam int BANKS  = (NUM_PINS + 31) / 32,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W = 3 + BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);

  localparam int TOT = BANKS * 32;
  localparam logic [TOT:0]   ONEX   = {{TOT{1'b0}}, 1'b1};
  localparam logic [TOT:0]   VALIDX = (ONEX << NUM_PINS) - ONEX;
  localparam logic [TOT-1:0] VALID  = VALIDX[TOT-1:0];

  localparam logic [2:0] F_OUT  = 3'd0;
  localparam logic [2:0] F_DIR  = 3'd1;
  localparam logic [2:0] F_LVL  = 3'd2;
  localparam logic [2:0] F_MASK = 3'd3;
  localparam logic [2:0] F_STAT = 3'd4;
  localparam logic [2:0] F_EDGE = 3'd5;
  localparam logic [2:0] F_EN   = 3'd6;

  logic [2:0]        field;
  logic [BANK_W-1:0] bank;
  logic              bank_ok;
  logic [TOT-1:0]    bank_m, wrep, wsel;

  assign field   = bus_addr[ADDR_W-1:BANK_W];
  assign bank    = bus_addr[BANK_W-1:0];
  assign bank_ok = int'(bank) < BANKS;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_m[b*32 +: 32] = {32{bank == BANK_W'(b)}};
    assign wrep[b*32 +: 32]   = bus_wdata;
  end

  assign wsel = bank_m & VALID;

  logic wr_hit;
  assign wr_hit = bus_sel & bus_wr;

  logic [TOT-1:0] dout_q, dir_q, mask_q, stat_q, etype_q, en_q;
  logic [TOT-1:0] s1, s2, s3, pad_x;
  logic [TOT-1:0] rise, fall, evt, hit, clr, en_eff, oe_x;

  assign pad_x = TOT'(pad_in);
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign evt   = HAS_EDGE ? ((rise & etype_q) | (fall & ~etype_q)) : s2;
  assign hit   = evt & ~mask_q & VALID;
  assign clr   = (wr_hit && field == F_STAT) ? (wsel & ~wrep) : '0;

  function automatic logic [TOT-1:0] merge(input logic [TOT-1:0] old,
                                           input logic [TOT-1:0] sel,
                                           input logic [TOT-1:0] val);
    return (old & ~sel) | (val & sel);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= VALID;
      mask_q  <= VALID;
      stat_q  <= '0;
      etype_q <= '0;
      en_q    <= '0;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
    end else begin
      s1 <= pad_x;
      s2 <= s1;
      s3 <= s2;
      stat_q <= (stat_q & ~clr) | hit;
      if (wr_hit) begin
        case (field)
          F_OUT:  dout_q <= merge(dout_q, wsel, wrep);
          F_DIR:  dir_q  <= merge(dir_q, wsel, wrep);
          F_MASK: mask_q <= merge(mask_q, wsel, wrep);
          F_EDGE: if (HAS_EDGE) etype_q <= merge(etype_q, wsel, wrep);
          F_EN:   if (HAS_ENABLE) en_q <= merge(en_q, wsel, wrep);
          default: ;
        endcase
      end
    end
  end

  logic [TOT-1:0] rv;
  always_comb begin
    case (field)
      F_OUT:   rv = dout_q;
      F_DIR:   rv = dir_q;
      F_LVL:   rv = s2;
      F_MASK:  rv = mask_q;
      F_STAT:  rv = stat_q;
      F_EDGE:  rv = etype_q;
      F_EN:    rv = en_q;
      default: rv = '0;
    endcase
  end

  assign bus_rdata = bank_ok ? rv[32*int'(bank) +: 32] : '0;

  assign en_eff  = HAS_ENABLE ? en_q : VALID;
  assign oe_x    = ~dir_q & en_eff & VALID;
  assign pad_oe  = oe_x[NUM_PINS-1:0];
  assign pad_out = dout_q[NUM_PINS-1:0];
  assign irq     = |stat_q;

endmodule

// File: rtl/gpio_bank_ctl_chk.sv
module gpio_bank_ctl_chk #(
  parameter int NUM_PINS = 40,
  localparam int BANKS  = (NUM_PINS + 31) / 32,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W = 3 + BANK_W,
  localparam int TOT    = BANKS * 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic                irq,
  input logic [TOT-1:0]      stat_q,
  input logic [TOT-1:0]      hit
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  logic [TOT-1:0] clr_v;
  always_comb begin
    clr_v = '0;
    for (int b = 0; b < BANKS; b++)
      if (bus_addr[BANK_W-1:0] == BANK_W'(b)) clr_v[b*32 +: 32] = ~bus_wdata;
  end

  logic        wr_stat, rd_lvl0;
  logic [31:0] pad0;
  assign wr_stat = bus_sel & bus_wr & (bus_addr[ADDR_W-1:BANK_W] == 3'd4);
  assign rd_lvl0 = bus_sel & !bus_wr & (bus_addr == {3'd2, BANK_W'(0)});
  assign pad0    = 32'(pad_in);

  a_r5_level_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && rd_lvl0) |-> bus_rdata == $past(pad0, 2));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

  a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(clr_v & ~hit)) == '0));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit) != '0));

endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .irq(irq), .stat_q(stat_q), .hit(hit)
);

// File: tb/test_gpio_bank_ctl.sv
module test_gpio_bank_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;

  logic        a_sel = 0, a_wr = 0, a_irq;
  logic [3:0]  a_addr = '0;
  logic [31:0] a_wd = '0, a_rd;
  logic [39:0] a_pin = '0, a_pout, a_poe;

  logic        l_sel = 0, l_wr = 0, l_irq;
  logic [3:0]  l_addr = '0;
  logic [31:0] l_wd = '0, l_rd;
  logic [19:0] l_pin = '0, l_pout, l_poe;

  gpio_bank_ctl #(.NUM_PINS(40), .HAS_EDGE(1'b1), .HAS_ENABLE(1'b1)) i_gpio_bank_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(a_sel), .bus_wr(a_wr), .bus_addr(a_addr),
    .bus_wdata(a_wd), .bus_rdata(a_rd), .pad_in(a_pin), .pad_out(a_pout),
    .pad_oe(a_poe), .irq(a_irq));

  gpio_bank_ctl #(.NUM_PINS(20), .HAS_EDGE(1'b0), .HAS_ENABLE(1'b0)) i_gpio_bank_ctl_lvl (
    .clk(clk), .rst_n(rst_n), .bus_sel(l_sel), .bus_wr(l_wr), .bus_addr(l_addr),
    .bus_wdata(l_wd), .bus_rdata(l_rd), .pad_in(l_pin), .pad_out(l_pout),
    .pad_oe(l_poe), .irq(l_irq));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_a(int f, int b, logic [31:0] d);
    @(negedge clk);
    a_sel = 1; a_wr = 1; a_addr = {3'(f), 1'(b)}; a_wd = d;
    @(negedge clk);
    a_sel = 0; a_wr = 0;
  endtask

  task automatic rd_a(int f, int b, output logic [31:0] d);
    a_sel = 1; a_wr = 0; a_addr = {3'(f), 1'(b)};
    #1 d = a_rd;
    a_sel = 0;
  endtask

  task automatic wr_l(int f, int b, logic [31:0] d);
    @(negedge clk);
    l_sel = 1; l_wr = 1; l_addr = {3'(f), 1'(b)}; l_wd = d;
    @(negedge clk);
    l_sel = 0; l_wr = 0;
  endtask

  task automatic rd_l(int f, int b, output logic [31:0] d);
    l_sel = 1; l_wr = 0; l_addr = {3'(f), 1'(b)};
    #1 d = l_rd;
    l_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd_a(1, 0, d); chk("R1 dir bank0", d, 32'hFFFF_FFFF);
    rd_a(1, 1, d); chk("R1 dir bank1", d, 32'h0000_00FF);
    rd_a(3, 0, d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
    rd_a(4, 1, d); chk("R1 status bank1", d, 0);
    chk("R1 irq", a_irq, 0);
    chk("R1 pad_oe", a_poe, 0);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    wr_a(0, 1, 32'h0000_0005);
    wr_a(1, 1, 32'hFFFF_FFF0);
    wr_a(6, 1, 32'h0000_0003);
    chk("R3 pad_oe", a_poe, 40'h03_0000_0000);
    chk("R3 pad_out", a_pout[39:32], 8'h05);
    rd_a(1, 1, d); chk("R10 dir upper bits", d, 32'h0000_00F0);
    wr_a(6, 1, 32'h0);
    chk("R4 enable clear", a_poe, 0);
    wr_a(1, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    a_pin = 40'h12_3456_789A;
    @(negedge clk);
    rd_a(2, 0, d); chk("R5 level not yet", d, 32'h0);
    @(negedge clk);
    rd_a(2, 0, d); chk("R5 level bank0", d, 32'h3456_789A);
    rd_a(2, 1, d); chk("R5 level bank1", d, 32'h0000_0012);
    @(negedge clk);
    rd_a(4, 0, d); chk("R7 masked status", d, 0);
    chk("R7 masked irq", a_irq, 0);
    a_pin = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr_a(5, 0, 32'h0000_0001);
    wr_a(3, 0, 32'hFFFF_FFFC);
    a_pin[1:0] = 2'b11;
    repeat (2) @(negedge clk);
    rd_a(4, 0, d); chk("R6 status not before third edge", d, 0);
    @(negedge clk);
    rd_a(4, 0, d); chk("R6 rising only", d, 32'h1);
    chk("R9 irq set", a_irq, 1);
    a_pin[1:0] = 2'b00;
    repeat (3) @(negedge clk);
    rd_a(4, 0, d); chk("R6 falling", d, 32'h3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr_a(4, 0, 32'hFFFF_FFFE);
    rd_a(4, 0, d); chk("R8 partial clear", d, 32'h2);
    chk("R9 irq still set", a_irq, 1);
    wr_a(4, 0, 32'h0);
    rd_a(4, 0, d); chk("R8 full clear", d, 0);
    chk("R9 irq low", a_irq, 0);
  endtask

  task automatic t_bank1();
    logic [31:0] d;
    wr_a(5, 1, 32'h0000_0002);
    wr_a(3, 1, 32'hFFFF_FFFD);
    a_pin[33] = 1'b1;
    repeat (3) @(negedge clk);
    rd_a(4, 1, d); chk("R2 pin33 status", d, 32'h2);
    rd_a(4, 0, d); chk("R2 bank0 untouched", d, 0);
    chk("R9 irq bank1", a_irq, 1);
    wr_a(4, 1, 32'h0);
    chk("R9 irq cleared", a_irq, 0);
    a_pin[33] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr_a(0, 1, 32'hFFFF_FFFF);
    rd_a(0, 1, d); chk("R10 out upper", d, 32'h0000_00FF);
    wr_a(5, 1, 32'hFFFF_FFFF);
    rd_a(5, 1, d); chk("R10 edge upper", d, 32'h0000_00FF);
    wr_a(3, 1, 32'h0);
    rd_a(3, 1, d); chk("R10 mask upper", d, 0);
    repeat (3) @(negedge clk);
    rd_a(4, 1, d); chk("R10 no status", d, 0);
  endtask

  task automatic t_lvl();
    logic [31:0] d;
    wr_l(3, 0, 32'hFFFF_FFF7);
    l_pin[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd_l(4, 0, d); chk("R11 level status", d, 32'h8);
    chk("R9 level irq", l_irq, 1);
    wr_l(4, 0, 32'h0);
    rd_l(4, 0, d); chk("R11 clear while high", d, 32'h8);
    l_pin[3] = 1'b0;
    repeat (3) @(negedge clk);
    wr_l(4, 0, 32'h0);
    rd_l(4, 0, d); chk("R11 clear after low", d, 0);
    wr_l(5, 0, 32'hFFFF_FFFF);
    rd_l(5, 0, d); chk("R11 edge field reads 0", d, 0);
    wr_l(0, 0, 32'h1);
    wr_l(1, 0, 32'hFFFF_FFFE);
    chk("R12 drives without enable", l_poe, 20'h1);
    chk("R12 pad_out", l_pout, 20'h1);
    wr_l(6, 0, 32'hFFFF_FFFF);
    rd_l(6, 0, d); chk("R12 enable reads 0", d, 0);
    rd_l(1, 1, d); chk("R2 bank past end", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_level();
    t_edge();
    t_clear();
    t_bank1();
    t_upper();
    t_lvl();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule